// File: doc/BRIEF.md
# Scanline Pixel Packing FIFO

This block sits between a pixel-producing stage and a memory-write engine in a video capture path. Each cycle it may receive one 16-bit RGB565 pixel. It joins consecutive pixels two at a time into a 32-bit word. The earlier pixel of each pair sits in the low half of the word. The joined words go into a 32-entry first-in first-out buffer. The write engine drains that buffer through a valid/ready handshake and copies the words to a framebuffer in the order they were produced.

A pulse on the line-start input marks the beginning of every scanline. The pulse empties the buffer and discards any half-built pair. This clean-up is deliberate, so it never counts as an error. The block also shows how many words are currently held. It raises a sticky interrupt when a finished word cannot be stored because the buffer is full and nothing drains in that cycle. The word that could not be stored is dropped. Software clears the interrupt with a one-cycle clear pulse.

Top module: `scanline_pack_fifo`

## Requirements
- R1: Two accepted pixels form one word. The first pixel of the pair occupies bits 15:0 and the second occupies bits 31:16. The word is written on the clock edge at which the second pixel is accepted.
- R2: The buffer holds up to 32 words, which is 64 pixels. Words leave in the order they were written.
- R3: `fill_words_o` equals the number of stored words, from 0 to 32. It updates on the edge that writes or reads a word.
- R4: `rd_valid_o` is high exactly when at least one word is stored. `rd_data_o` presents the oldest word. A word is removed on an edge where both `rd_valid_o` and `rd_ready_i` are high.
- R5: On an edge where `line_start_i` is high, all stored words are discarded. After that edge, `fill_words_o` is 0 and `rd_valid_o` is low.
- R6: On the same edge, the line-start pulse also discards a held first-of-pair pixel. A pixel presented in the line-start cycle becomes the low half of the next word.
- R7: Discarding data on a line-start edge never sets `ovf_irq_o`.
- R8: A word may complete while 32 words are stored and no read happens in that cycle. In that case `ovf_irq_o` goes high after the edge, the word is dropped, and `fill_words_o` stays 32.
- R9: A word may complete while the buffer is full and a read does happen in the same cycle. In that case the word is stored, `fill_words_o` stays 32, and `ovf_irq_o` is not set.
- R10: `ovf_irq_o` stays high until an edge with `ovf_clr_i` high. If a new overflow occurs in the same cycle as the clear, the flag stays set.
- R11: After reset, `fill_words_o` is 0, `rd_valid_o` is low, `ovf_irq_o` is low, and no pixel is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle pulse at the start of a scanline; flushes the block |
| pix_valid_i | input | 1 | A pixel is presented this cycle |
| pix_data_i | input | 16 | RGB565 pixel |
| rd_valid_o | output | 1 | A stored word is available |
| rd_data_o | output | 32 | Oldest stored word |
| rd_ready_i | input | 1 | Drain side takes the word this cycle |
| fill_words_o | output | 6 | Number of stored words |
| ovf_irq_o | output | 1 | Sticky overflow interrupt |
| ovf_clr_i | input | 1 | Clears the overflow interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the fill count never exceeds the depth;
- a full buffer stays full both when it drops a word and when it swaps one in and one out;
- a line-start edge always leaves the buffer empty without touching the interrupt;
- the interrupt is sticky and is raised by every overflow;
- no two words complete on consecutive cycles.

Other behaviour can only be shown by the directed scenarios, because it depends on the data values:
- the half-word placement of pixels;
- the word order over a full 32-entry run;
- the fact that the dropped word is really absent from the read stream;
- the realignment of pairing after a flush that falls mid-pair.

// File: rtl/scanline_pack_pkg.sv
package scanline_pack_pkg;

    // Pairing state of the pixel packer
    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_HELD  = 1'b1
    } pair_state_e;

    // Next index of a circular buffer of the given depth
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/spk_pair_packer.sv
module spk_pair_packer
    import scanline_pack_pkg::*;
#(
    parameter int unsigned PIX_W = 16,
    localparam int unsigned WORD_W = 2 * PIX_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              pix_valid_i,
    input  logic [PIX_W-1:0]  pix_data_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o
);

    typedef struct packed {
        pair_state_e      st;
        logic [PIX_W-1:0] low;
    } pack_state_t;

    pack_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        word_valid_o = 1'b0;
        word_data_o  = {pix_data_i, s_q.low};
        if (flush_i) begin
            // a pixel arriving with the flush starts the new line
            s_d.st = pix_valid_i ? PAIR_HELD : PAIR_EMPTY;
            if (pix_valid_i) begin
                s_d.low = pix_data_i;
            end
        end else if (pix_valid_i) begin
            if (s_q.st == PAIR_EMPTY) begin
                s_d.st  = PAIR_HELD;
                s_d.low = pix_data_i;
            end else begin
                s_d.st       = PAIR_EMPTY;
                word_valid_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: PAIR_EMPTY, low: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_NO_BACK_TO_BACK_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |=> !word_valid_o) else $error("pair packer emitted two words in a row"); // R1

endmodule

// File: rtl/spk_word_fifo.sv
module spk_word_fifo
    import scanline_pack_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_ready_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_evt_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [WORD_W-1:0] mem_q [DEPTH];

    logic full, rd_fire, wr_en;

    always_comb begin
        s_d       = s_q;
        full      = (s_q.cnt == CNT_W'(DEPTH));
        rd_fire   = (s_q.cnt != '0) && rd_ready_i;
        wr_en     = wr_valid_i && (!full || rd_fire) && !flush_i;
        ovf_evt_o = wr_valid_i && full && !rd_fire && !flush_i;
        if (flush_i) begin
            s_d = '0;
        end else begin
            if (rd_fire) begin
                s_d.rp = PTR_W'(ring_next(int'(s_q.rp), DEPTH));
            end
            if (wr_en) begin
                s_d.wp = PTR_W'(ring_next(int'(s_q.wp), DEPTH));
            end
            s_d.cnt = s_q.cnt + CNT_W'(wr_en) - CNT_W'(rd_fire);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en) begin
            mem_q[s_q.wp] <= wr_data_i;
        end
    end

    assign rd_valid_o = (s_q.cnt != '0);
    assign rd_data_o  = mem_q[s_q.rp];
    assign count_o    = s_q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_W'(DEPTH)) else $error("fill count above depth"); // R3
    AST_FULL_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == CNT_W'(DEPTH) && !rd_ready_i && !flush_i) |=> count_o == CNT_W'(DEPTH)) else $error("full buffer changed without read"); // R8
    AST_FULL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == CNT_W'(DEPTH) && rd_ready_i && wr_valid_i && !flush_i) |=> count_o == CNT_W'(DEPTH)) else $error("swap at full lost a word"); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (count_o == '0 && !rd_valid_o)) else $error("flush left words behind"); // R5

endmodule

// File: rtl/spk_ovf_flag.sv
module spk_ovf_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_i) begin
            s_d.flag = 1'b1;
        end else if (clr_i) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o = s_q.flag;

    AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o) else $error("overflow not flagged"); // R8
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i) |=> flag_o) else $error("overflow flag dropped without clear"); // R10

endmodule

// File: rtl/scanline_pack_fifo.sv
module scanline_pack_fifo #(
    parameter int unsigned PIX_W = 16,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned WORD_W = 2 * PIX_W,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              line_start_i,
    input  logic              pix_valid_i,
    input  logic [PIX_W-1:0]  pix_data_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              rd_ready_i,
    output logic [CNT_W-1:0]  fill_words_o,
    output logic              ovf_irq_o,
    input  logic              ovf_clr_i
);

    logic              word_valid;
    logic [WORD_W-1:0] word_data;
    logic              ovf_evt;

    spk_pair_packer #(.PIX_W(PIX_W)) packer_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flush_i      (line_start_i),
        .pix_valid_i  (pix_valid_i),
        .pix_data_i   (pix_data_i),
        .word_valid_o (word_valid),
        .word_data_o  (word_data)
    );

    spk_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (line_start_i),
        .wr_valid_i (word_valid),
        .wr_data_i  (word_data),
        .rd_ready_i (rd_ready_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .count_o    (fill_words_o),
        .ovf_evt_o  (ovf_evt)
    );

    spk_ovf_flag ovf_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (ovf_evt),
        .clr_i  (ovf_clr_i),
        .flag_o (ovf_irq_o)
    );

    AST_FLUSH_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_start_i && !ovf_irq_o) |=> !ovf_irq_o) else $error("flush raised overflow"); // R7
    AST_VALID_TRACKS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o == (fill_words_o != '0)) else $error("valid disagrees with fill"); // R4

endmodule

// File: tb/scanline_pack_fifo_tb.sv
`timescale 1ns/1ps
module scanline_pack_fifo_tb_top;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_ready = 1'b0;
    logic [5:0]  fill;
    logic        irq;
    logic        irq_clr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scanline_pack_fifo dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .line_start_i (line_start),
        .pix_valid_i  (pix_valid),
        .pix_data_i   (pix_data),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .rd_ready_i   (rd_ready),
        .fill_words_o (fill),
        .ovf_irq_o    (irq),
        .ovf_clr_i    (irq_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] p);
        pix_valid = 1'b1;
        pix_data  = p;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        check({req, " valid"}, 32'(rd_valid), 32'd1);
        check(req, rd_data, exp);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic flush();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    function automatic logic [31:0] wd(input logic [15:0] base, input int k);
        return {base + 16'(2 * k + 1), base + 16'(2 * k)};
    endfunction

    task automatic fill_full(input logic [15:0] base);
        for (int i = 0; i < 2 * DEPTH; i++) send(base + 16'(i));
    endtask

    task automatic t_reset();
        check("R11 fill", 32'(fill), 0);
        check("R11 valid", 32'(rd_valid), 0);
        check("R11 irq", 32'(irq), 0);
    endtask

    task automatic t_pack();
        send(16'h1111);
        check("R1 no word after one pixel", 32'(fill), 0);
        send(16'h2222);
        send(16'h3333);
        send(16'h4444);
        check("R3 fill two", 32'(fill), 2);
        read_word("R1 first word", 32'h2222_1111);
        check("R3 fill after read", 32'(fill), 1);
        read_word("R4 second word", 32'h4444_3333);
        check("R4 empty valid", 32'(rd_valid), 0);
    endtask

    task automatic t_full_order();
        fill_full(16'h0100);
        check("R2 fill full", 32'(fill), DEPTH);
        check("R8 no irq at exactly full", 32'(irq), 0);
        for (int k = 0; k < DEPTH; k++) read_word("R2 order", wd(16'h0100, k));
        check("R3 drained", 32'(fill), 0);
    endtask

    task automatic t_overflow();
        fill_full(16'h0200);
        send(16'hEEE0);
        send(16'hEEE1);
        check("R8 irq set", 32'(irq), 1);
        check("R8 fill stays", 32'(fill), DEPTH);
        repeat (3) @(negedge clk);
        check("R10 irq sticky", 32'(irq), 1);
        for (int k = 0; k < DEPTH; k++) read_word("R8 stored words", wd(16'h0200, k));
        check("R8 dropped word absent", 32'(rd_valid), 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_swap();
        fill_full(16'h0300);
        send(16'hAAAA);
        check("R9 head word", rd_data, wd(16'h0300, 0));
        pix_valid = 1'b1;
        pix_data  = 16'hBBBB;
        rd_ready  = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        rd_ready  = 1'b0;
        check("R9 no irq", 32'(irq), 0);
        check("R9 fill full", 32'(fill), DEPTH);
        for (int k = 1; k < DEPTH; k++) read_word("R9 old words", wd(16'h0300, k));
        read_word("R9 new word kept", 32'hBBBB_AAAA);
    endtask

    task automatic t_flush();
        fill_full(16'h0400);
        send(16'h5555);
        send(16'h6666);
        check("R7 irq before flush", 32'(irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        send(16'h7777);
        flush();
        check("R5 fill zero", 32'(fill), 0);
        check("R5 valid low", 32'(rd_valid), 0);
        check("R7 no irq from flush", 32'(irq), 0);
        send(16'h8001);
        send(16'h8002);
        read_word("R6 half pair discarded", 32'h8002_8001);
        send(16'h9001);
        line_start = 1'b1;
        pix_valid  = 1'b1;
        pix_data   = 16'h9002;
        @(negedge clk);
        line_start = 1'b0;
        pix_valid  = 1'b0;
        check("R6 no word on flush edge", 32'(fill), 0);
        send(16'h9003);
        read_word("R6 flush-cycle pixel is low half", 32'h9003_9002);
    endtask

    task automatic t_set_wins();
        fill_full(16'h0500);
        send(16'hC000);
        pix_valid = 1'b1;
        pix_data  = 16'hC001;
        irq_clr   = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        irq_clr   = 1'b0;
        check("R10 set beats clear", 32'(irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 clear alone", 32'(irq), 0);
        flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_full_order();
        t_overflow();
        t_swap();
        t_flush();
        t_set_wins();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule